// File: doc/BRIEF.md
# Split-View Inter-Processor Doorbell Mailbox

This block carries doorbell flags from a sending processor to a receiving processor. Each one-way channel holds a 32-bit status word. The sender raises flags through its own register window. The receiver sees the flags in its own window, takes an interrupt and clears what it has handled. Bits 30:0 are message slots. Bit 31 is kept for hardware: it marks an attempt to write the channel with a non-secure access.

The sender window also holds a wake handshake. The sender raises a request line to the receiver side and waits for a ready flag. The flag rises after a modelled power-up delay, and only then does the sender post flags. Both windows have a read-only capability word that reports the number of channels built into the instance. Both register ports are simple single-cycle buses. A write takes effect at the clock edge where select is sampled. Read data is registered and appears in the following cycle.

Top module: `dbm_top`

## Requirements
- R1: Channel n occupies byte offsets n*0x20 to n*0x20+0x1F in each window. Status reads at channel offset 0x0 in both windows. The sender raises flags at offset 0xC and the receiver clears flags at offset 0x8. Offset 0xF80 in both windows reads the channel count. Read data appears on the rdata port one cycle after the read is sampled.
- R2: A secure sender write to offset 0xC ORs bits 30:0 of the written word into that channel's status. Bit 31 of the written word is ignored.
- R3: A secure receiver write to offset 0x8 clears every status bit, bit 31 included, whose written bit is 1. Bits written as 0 leave the status unchanged.
- R4: After reset every status word is zero, every interrupt is low, and both the wake request and the ready flag are 0.
- R5: When a set and a clear reach the same channel in one cycle, the new status is (old AND NOT clear) OR set. A set therefore wins over a clear of the same bit.
- R6: A channel's interrupt output is high exactly when any of bits 30:0 of its status is 1. It changes at the same clock edge as the status.
- R7: A non-secure write anywhere in a channel's 0x20-byte range, in either window, sets bit 31 of that channel and has no other effect. A non-secure write outside the channel ranges has no effect. A non-secure read returns zero.
- R8: A secure write to sender offset 0xF88 stores bit 0 of the word as the wake request. The value reads back at that offset and drives the wake_req port.
- R9: Sender offset 0xF8C reads 1 in bit 0 exactly WAKE_DLY clock edges after the edge at which the request becomes 1. It returns to 0 one edge after the request is cleared.
- R10: Unmapped offsets read zero. Writes to status, capability and ready offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snd_sel | input | 1 | Sender window access strobe |
| snd_wr | input | 1 | Sender write (1) or read (0) |
| snd_ns | input | 1 | Sender access is non-secure |
| snd_addr | input | AW (12) | Sender byte offset |
| snd_wdata | input | 32 | Sender write data |
| snd_rdata | output | 32 | Sender read data, registered |
| rcv_sel | input | 1 | Receiver window access strobe |
| rcv_wr | input | 1 | Receiver write (1) or read (0) |
| rcv_ns | input | 1 | Receiver access is non-secure |
| rcv_addr | input | AW (12) | Receiver byte offset |
| rcv_wdata | input | 32 | Receiver write data |
| rcv_rdata | output | 32 | Receiver read data, registered |
| rcv_irq | output | NCH (4) | Per-channel receiver interrupt |
| wake_req | output | 1 | Wake request toward the receiver side |

## Verification
A sender raise and a receiver clear can land on the same channel in the same cycle, and so can a non-secure mark of bit 31 and a receiver clear of that bit. The bench drives both register ports on the same falling edge, so both updates are sampled by one rising edge. It first preloads the channel so that some cleared bits are also raised and others are not. The bench judges the result against (old AND NOT clear) OR set, read from both windows, and against the interrupt line. One case clears every slot while a single slot is raised, so the interrupt must stay high.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam logic [4:0]  OFS_STAT = 5'h00;
  localparam logic [4:0]  OFS_CLR  = 5'h08;
  localparam logic [4:0]  OFS_SET  = 5'h0C;
  localparam int unsigned CH_SHIFT = 5;
  localparam int unsigned ADR_CAP  = 'hF80;
  localparam int unsigned ADR_REQ  = 'hF88;
  localparam int unsigned ADR_RDY  = 'hF8C;
  localparam logic [31:0] SLOT_MASK = 32'h7FFF_FFFF;
  localparam logic [31:0] NS_FLAG   = 32'h8000_0000;
endpackage

// File: rtl/dbm_chan.sv
module dbm_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [DW-1:0] set_data,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_data,
  input  logic          ns_mark,
  output logic [DW-1:0] stat,
  output logic          irq
);
  logic [DW-1:0] stat_q, stat_nxt;
  logic          irq_q;

  always_comb begin
    stat_nxt = stat_q;
    if (clr_en) stat_nxt = stat_nxt & ~clr_data;
    if (set_en) stat_nxt = stat_nxt | {1'b0, set_data[DW-2:0]};
    if (ns_mark) stat_nxt[DW-1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_nxt;
      irq_q  <= |stat_nxt[DW-2:0];
    end
  end

  assign stat = stat_q;
  assign irq  = irq_q;

  p_reset_clear_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (stat_q == '0 && !irq_q));
  p_set_lands_r2: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((stat_q[DW-2:0] & $past(set_data[DW-2:0])) == $past(set_data[DW-2:0])));
  p_clr_lands_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en && !ns_mark) |=> ((stat_q & $past(clr_data)) == '0));
  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_en && set_en) |=> ((stat_q[DW-2:0] & $past(set_data[DW-2:0])) == $past(set_data[DW-2:0])));
  p_flag_source_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[DW-1]) |-> $past(ns_mark));
  p_irq_source_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(set_en));
endmodule

// File: rtl/dbm_wake.sv
module dbm_wake #(
  parameter int WAKE_DLY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic req_wr,
  input  logic req_val,
  output logic req,
  output logic rdy
);
  localparam int CW = (WAKE_DLY < 2) ? 1 : $clog2(WAKE_DLY);
  localparam logic [CW-1:0] CNT_LAST = CW'(WAKE_DLY - 1);

  logic          req_q, rdy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (req_wr) req_q <= req_val;
      if (!req_q) begin
        rdy_q <= 1'b0;
        cnt_q <= '0;
      end else if (!rdy_q) begin
        if (cnt_q == CNT_LAST) rdy_q <= 1'b1;
        else cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign req = req_q;
  assign rdy = rdy_q;

  p_rdy_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> $past(req_q));
  p_rdy_drops_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(req_q) |=> !rdy_q);
  p_req_follows_write_r8: assert property (@(posedge clk) disable iff (rst)
    req_wr |=> (req_q == $past(req_val)));
endmodule

// File: rtl/dbm_win.sv
module dbm_win
  import dbm_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int AW        = 12,
  parameter int DW        = 32,
  parameter bit IS_SENDER = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sel,
  input  logic                   wr,
  input  logic                   ns,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  input  logic [NCH-1:0][DW-1:0] stat_all,
  input  logic                   req_in,
  input  logic                   rdy_in,
  output logic [NCH-1:0]         act_vec,
  output logic [NCH-1:0]         ns_vec,
  output logic [DW-1:0]          act_data,
  output logic                   req_wr,
  output logic                   req_val,
  output logic [DW-1:0]          rdata
);
  localparam int            CHW    = (NCH < 2) ? 1 : $clog2(NCH);
  localparam logic [AW-1:0] CH_END = AW'(NCH << CH_SHIFT);
  localparam logic [AW-1:0] A_CAP  = AW'(ADR_CAP);
  localparam logic [AW-1:0] A_REQ  = AW'(ADR_REQ);
  localparam logic [AW-1:0] A_RDY  = AW'(ADR_RDY);
  localparam logic [4:0]    OFS_ACT = IS_SENDER ? OFS_SET : OFS_CLR;

  logic           in_ch;
  logic [CHW-1:0] ch_idx;
  logic [4:0]     ofs;
  logic           sec_wr, ns_wr, sec_rd;
  logic [DW-1:0]  rd_nxt, rdata_q;

  assign in_ch  = (addr < CH_END);
  assign ch_idx = addr[CH_SHIFT +: CHW];
  assign ofs    = addr[4:0];
  assign sec_wr = sel && wr && !ns;
  assign ns_wr  = sel && wr && ns;
  assign sec_rd = sel && !wr && !ns;
  assign act_data = wdata;

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign act_vec[g] = sec_wr && in_ch && (ch_idx == CHW'(g)) && (ofs == OFS_ACT);
    assign ns_vec[g]  = ns_wr && in_ch && (ch_idx == CHW'(g));
  end

  if (IS_SENDER) begin : g_snd
    assign req_wr  = sec_wr && (addr == A_REQ);
    assign req_val = wdata[0];
  end else begin : g_rcv
    assign req_wr  = 1'b0;
    assign req_val = 1'b0;
  end

  always_comb begin
    rd_nxt = '0;
    if (sec_rd) begin
      if (in_ch) begin
        if (ofs == OFS_STAT) rd_nxt = stat_all[ch_idx];
      end else if (addr == A_CAP) begin
        rd_nxt = DW'(NCH);
      end else if (IS_SENDER && addr == A_REQ) begin
        rd_nxt = {{(DW-1){1'b0}}, req_in};
      end else if (IS_SENDER && addr == A_RDY) begin
        rd_nxt = {{(DW-1){1'b0}}, rdy_in};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_nxt;
  end

  assign rdata = rdata_q;

  p_ns_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (sel && ns) |=> (rdata_q == '0));
  p_one_target_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({act_vec, ns_vec}));
endmodule

// File: rtl/dbm_top.sv
module dbm_top #(
  parameter int NCH      = 4,
  parameter int AW       = 12,
  parameter int DW       = 32,
  parameter int WAKE_DLY = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           snd_sel,
  input  logic           snd_wr,
  input  logic           snd_ns,
  input  logic [AW-1:0]  snd_addr,
  input  logic [DW-1:0]  snd_wdata,
  output logic [DW-1:0]  snd_rdata,
  input  logic           rcv_sel,
  input  logic           rcv_wr,
  input  logic           rcv_ns,
  input  logic [AW-1:0]  rcv_addr,
  input  logic [DW-1:0]  rcv_wdata,
  output logic [DW-1:0]  rcv_rdata,
  output logic [NCH-1:0] rcv_irq,
  output logic           wake_req
);
  logic [NCH-1:0][DW-1:0] stat_all;
  logic [NCH-1:0]         set_vec, clr_vec, s_ns_vec, r_ns_vec;
  logic [DW-1:0]          set_data, clr_data;
  logic                   req_wr, req_val, r_req_wr, r_req_val;
  logic                   req_q, rdy_q;

  dbm_win #(.NCH(NCH), .AW(AW), .DW(DW), .IS_SENDER(1'b1)) u_snd_win (
    .clk(clk), .rst(rst), .sel(snd_sel), .wr(snd_wr), .ns(snd_ns),
    .addr(snd_addr), .wdata(snd_wdata), .stat_all(stat_all),
    .req_in(req_q), .rdy_in(rdy_q), .act_vec(set_vec), .ns_vec(s_ns_vec),
    .act_data(set_data), .req_wr(req_wr), .req_val(req_val), .rdata(snd_rdata)
  );

  dbm_win #(.NCH(NCH), .AW(AW), .DW(DW), .IS_SENDER(1'b0)) u_rcv_win (
    .clk(clk), .rst(rst), .sel(rcv_sel), .wr(rcv_wr), .ns(rcv_ns),
    .addr(rcv_addr), .wdata(rcv_wdata), .stat_all(stat_all),
    .req_in(1'b0), .rdy_in(1'b0), .act_vec(clr_vec), .ns_vec(r_ns_vec),
    .act_data(clr_data), .req_wr(r_req_wr), .req_val(r_req_val), .rdata(rcv_rdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dbm_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst(rst),
      .set_en(set_vec[c]), .set_data(set_data),
      .clr_en(clr_vec[c]), .clr_data(clr_data),
      .ns_mark(s_ns_vec[c] | r_ns_vec[c]),
      .stat(stat_all[c]), .irq(rcv_irq[c])
    );
  end

  dbm_wake #(.WAKE_DLY(WAKE_DLY)) u_wake (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_val(req_val),
    .req(req_q), .rdy(rdy_q)
  );

  assign wake_req = req_q;

  p_rcv_no_req_r8: assert property (@(posedge clk) disable iff (rst)
    !(r_req_wr || r_req_val));
endmodule

// File: tb/dbm_top_tb_top.sv
module dbm_top_tb_top;
  localparam int NCH = 4;
  localparam int AW  = 12;
  localparam int DW  = 32;
  localparam int DLY = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           snd_sel = 0, snd_wr = 0, snd_ns = 0;
  logic [AW-1:0]  snd_addr = '0;
  logic [DW-1:0]  snd_wdata = '0;
  logic [DW-1:0]  snd_rdata;
  logic           rcv_sel = 0, rcv_wr = 0, rcv_ns = 0;
  logic [AW-1:0]  rcv_addr = '0;
  logic [DW-1:0]  rcv_wdata = '0;
  logic [DW-1:0]  rcv_rdata;
  logic [NCH-1:0] rcv_irq;
  logic           wake_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  dbm_top #(.NCH(NCH), .AW(AW), .DW(DW), .WAKE_DLY(DLY)) dut_i (
    .clk(clk), .rst(rst),
    .snd_sel(snd_sel), .snd_wr(snd_wr), .snd_ns(snd_ns), .snd_addr(snd_addr),
    .snd_wdata(snd_wdata), .snd_rdata(snd_rdata),
    .rcv_sel(rcv_sel), .rcv_wr(rcv_wr), .rcv_ns(rcv_ns), .rcv_addr(rcv_addr),
    .rcv_wdata(rcv_wdata), .rcv_rdata(rcv_rdata),
    .rcv_irq(rcv_irq), .wake_req(wake_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sacc(input logic wr, input logic ns, input logic [AW-1:0] a,
                      input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    snd_sel = 1; snd_wr = wr; snd_ns = ns; snd_addr = a; snd_wdata = d;
    @(negedge clk);
    snd_sel = 0; snd_wr = 0; snd_ns = 0;
    rd = snd_rdata;
  endtask

  task automatic racc(input logic wr, input logic ns, input logic [AW-1:0] a,
                      input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    rcv_sel = 1; rcv_wr = wr; rcv_ns = ns; rcv_addr = a; rcv_wdata = d;
    @(negedge clk);
    rcv_sel = 0; rcv_wr = 0; rcv_ns = 0;
    rd = rcv_rdata;
  endtask

  task automatic both(input logic s_ns, input logic [AW-1:0] sa, input logic [31:0] sd,
                      input logic r_ns, input logic [AW-1:0] ra, input logic [31:0] rdv);
    @(negedge clk);
    snd_sel = 1; snd_wr = 1; snd_ns = s_ns; snd_addr = sa; snd_wdata = sd;
    rcv_sel = 1; rcv_wr = 1; rcv_ns = r_ns; rcv_addr = ra; rcv_wdata = rdv;
    @(negedge clk);
    snd_sel = 0; snd_wr = 0; snd_ns = 0;
    rcv_sel = 0; rcv_wr = 0; rcv_ns = 0;
  endtask

  function automatic logic [AW-1:0] ca(input int ch, input int ofs);
    return AW'(ch * 32 + ofs);
  endfunction

  task automatic stat_both(input string tag, input int ch, input logic [31:0] exp);
    logic [31:0] rd;
    sacc(0, 0, ca(ch, 0), 0, rd);
    chk({tag, " snd"}, rd, exp);
    racc(0, 0, ca(ch, 0), 0, rd);
    chk({tag, " rcv"}, rd, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, pat, exp, cur;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R4 reset state
    chk("R4 irq", {28'b0, rcv_irq}, 0);
    chk("R4 wake_req", {31'b0, wake_req}, 0);
    for (int c = 0; c < NCH; c++) stat_both("R4 stat", c, 0);
    sacc(0, 0, 12'hF8C, 0, rd);
    chk("R4 ready", rd, 0);

    // R1 capability in both windows
    sacc(0, 0, 12'hF80, 0, rd);
    chk("R1 cap snd", rd, NCH);
    racc(0, 0, 12'hF80, 0, rd);
    chk("R1 cap rcv", rd, NCH);

    // R1 R2 R3 R6 per-channel sweep
    for (int c = 0; c < NCH; c++) begin
      pat = (32'h1 << (c * 7 + 1)) | (32'h0101_0101 * (c + 1)) | 32'h8000_0000;
      exp = pat & 32'h7FFF_FFFF;
      sacc(1, 0, ca(c, 12), pat, rd);
      chk("R6 irq on set", {31'b0, rcv_irq[c]}, 1);
      chk("R6 other irq idle", {28'b0, rcv_irq}, 32'(1 << c));
      stat_both("R2 set or bit31 masked", c, exp);
      sacc(1, 0, ca(c, 12), 32'h0000_0400, rd);
      exp = exp | 32'h0000_0400;
      stat_both("R2 set accumulates", c, exp);
      racc(1, 0, ca(c, 8), exp & 32'h0000_FFFF, rd);
      exp = exp & 32'hFFFF_0000;
      stat_both("R3 partial clear", c, exp);
      chk("R6 irq holds", {31'b0, rcv_irq[c]}, (exp != 0) ? 1 : 0);
      racc(1, 0, ca(c, 8), 32'hFFFF_FFFF, rd);
      chk("R6 irq drops", {31'b0, rcv_irq[c]}, 0);
      stat_both("R3 full clear", c, 0);
    end

    // R5 collision: set and clear same cycle
    sacc(1, 0, ca(2, 12), 32'h0000_00F0, rd);
    both(0, ca(2, 12), 32'h0000_0011, 0, ca(2, 8), 32'h0000_0030);
    stat_both("R5 set wins", 2, (32'hF0 & ~32'h30) | 32'h11);
    both(0, ca(2, 12), 32'h0000_0004, 0, ca(2, 8), 32'h7FFF_FFFF);
    stat_both("R5 clear all plus set", 2, 32'h4);
    chk("R5 R6 irq stays", {31'b0, rcv_irq[2]}, 1);
    racc(1, 0, ca(2, 8), 32'hFFFF_FFFF, rd);

    // R7 non-secure marks bit 31 only
    sacc(1, 1, ca(1, 12), 32'h0000_FFFF, rd);
    stat_both("R7 ns set marks", 1, 32'h8000_0000);
    chk("R7 R6 ns no irq", {31'b0, rcv_irq[1]}, 0);
    racc(1, 1, ca(1, 8), 32'h8000_0000, rd);
    stat_both("R7 ns clear ignored", 1, 32'h8000_0000);
    racc(1, 0, ca(1, 8), 32'h8000_0000, rd);
    stat_both("R3 bit31 cleared", 1, 0);
    racc(1, 1, ca(3, 16), 32'h1, rd);
    stat_both("R7 ns rcv other offset", 3, 32'h8000_0000);
    both(1, ca(3, 0), 32'h0, 0, ca(3, 8), 32'h8000_0000);
    stat_both("R5 R7 mark wins clear", 3, 32'h8000_0000);
    racc(1, 0, ca(3, 8), 32'h8000_0000, rd);
    sacc(1, 0, ca(0, 12), 32'h5, rd);
    sacc(0, 1, ca(0, 0), 0, rd);
    chk("R7 ns read zero snd", rd, 0);
    racc(0, 1, ca(0, 0), 0, rd);
    chk("R7 ns read zero rcv", rd, 0);
    sacc(1, 1, 12'hF88, 32'h1, rd);
    chk("R7 ns req ignored", {31'b0, wake_req}, 0);

    // R10 unmapped and read-only
    sacc(0, 0, ca(0, 16), 0, rd);
    chk("R10 unmapped in ch", rd, 0);
    sacc(0, 0, 12'h400, 0, rd);
    chk("R10 unmapped high", rd, 0);
    racc(0, 0, 12'hF88, 0, rd);
    chk("R10 rcv no req reg", rd, 0);
    sacc(1, 0, ca(0, 0), 32'hFFFF_0000, rd);
    racc(1, 0, ca(0, 0), 32'hFFFF_FFFF, rd);
    sacc(1, 0, ca(0, 8), 32'h0000_0F00, rd);
    racc(1, 0, ca(0, 12), 32'h0000_00F0, rd);
    stat_both("R10 status write ignored", 0, 32'h5);
    sacc(1, 0, 12'hF80, 32'h55, rd);
    sacc(0, 0, 12'hF80, 0, rd);
    chk("R10 cap write ignored", rd, NCH);
    sacc(1, 0, 12'hF8C, 32'h1, rd);
    sacc(0, 0, 12'hF8C, 0, rd);
    chk("R10 ready write ignored", rd, 0);
    racc(1, 0, ca(0, 8), 32'hFFFF_FFFF, rd);

    // R8 R9 wake handshake
    sacc(1, 0, 12'hF88, 32'h3, rd);
    chk("R8 wake_req set", {31'b0, wake_req}, 1);
    snd_sel = 1; snd_wr = 0; snd_addr = 12'hF8C;
    for (int j = 1; j <= DLY + 2; j++) begin
      @(negedge clk);
      chk("R9 ready rise", snd_rdata, (j >= DLY + 1) ? 1 : 0);
    end
    snd_sel = 0;
    sacc(0, 0, 12'hF88, 0, rd);
    chk("R8 req readback", rd, 1);
    sacc(1, 0, 12'hF88, 32'h0, rd);
    chk("R8 wake_req clear", {31'b0, wake_req}, 0);
    snd_sel = 1; snd_wr = 0; snd_addr = 12'hF8C;
    for (int j = 1; j <= 3; j++) begin
      @(negedge clk);
      chk("R9 ready fall", snd_rdata, (j == 1) ? 1 : 0);
    end
    snd_sel = 0;
    sacc(1, 0, 12'hF88, 32'h1, rd);
    sacc(1, 0, 12'hF88, 32'h0, rd);
    repeat (DLY + 2) @(negedge clk);
    sacc(0, 0, 12'hF8C, 0, rd);
    chk("R9 short pulse no ready", rd, 0);

    cur = 0;
    chk("R6 final irq", {28'b0, rcv_irq}, cur);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule